// File: doc/BRIEF.md
# Machine Timer With External Reference Tick

This block is a memory-mapped machine timer for a small processor system. It keeps a 32-bit time count and a 32-bit compare value, both readable and writable over a simple single-cycle register bus. The count does not advance on the system clock. Instead it advances once for every rising edge seen on an external 1 MHz reference input, so software sees a microsecond time base whatever the core clock frequency.

The reference input is asynchronous to the system clock. It passes through a two-flop synchroniser, and a third flop detects the rising edge. A timer interrupt level is raised whenever the count has reached the compare value. Software clears the interrupt by writing a larger compare value. After reset the compare value is all ones, so no interrupt fires until software programs the compare register.

Top module: `mtimer_ext_tick`

## Requirements
- R1: After reset the time count reads 0, the compare value reads 0xFFFFFFFF, and `timer_irq` is low.
- R2: A rising edge of `ref_tick` is first sampled high at clock edge k, after being sampled low at edge k-1. This raises the time count by exactly one, visible after clock edge k+2.
- R3: The count does not change while `ref_tick` is held high or held low, and a falling edge of `ref_tick` does not change it.
- R4: `bus_rdata` returns, in the same cycle as `bus_addr`, the time count at byte offset 0x0 and the compare value at byte offset 0x4. Any other offset reads as zero.
- R5: A write (`bus_sel` and `bus_we` high) to offset 0x0 loads the time count, and a write to offset 0x4 loads the compare value. Either load is visible after that clock edge.
- R6: When a time write and a reference increment fall on the same clock edge, the written value is loaded and the increment is dropped.
- R7: `timer_irq` is high exactly when the time count is greater than or equal to the compare value, compared as unsigned numbers. For example, with the count at 0x7FFFFFFF and the compare value at 0x80000000, the interrupt is low.
- R8: An increment from 0xFFFFFFFF wraps the time count to 0.
- R9: A write to any offset other than 0x0 and 0x4 changes neither register. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Asynchronous 1 MHz reference; each rising edge advances the count |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable; qualifies `bus_sel` |
| bus_addr | input | 4 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timer_irq | output | 1 | Timer interrupt level |

## Verification
The assertions assume that `ref_tick` stays at each level for at least two system clocks. They also assume that the bus inputs are stable around each rising clock edge, so that the synchronised edge strobe and the write strobes are clean single-cycle events. The bench drives all inputs one nanosecond after the rising edge. It holds each reference level for three or more cycles, except in the collision test, which deliberately times a reference edge so that its increment falls on the same clock edge as a time write.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    // Which register a bus offset selects
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_TIME = 2'd1,
        REG_CMP  = 2'd2
    } reg_sel_e;

    // Decoded write strobes for one cycle
    typedef struct packed {
        logic time_wr;
        logic cmp_wr;
    } wr_ctl_t;

    function automatic reg_sel_e decode_offset(input int unsigned ofs,
                                               input int unsigned time_ofs,
                                               input int unsigned cmp_ofs);
        if (ofs == time_ofs)     return REG_TIME;
        else if (ofs == cmp_ofs) return REG_CMP;
        else                     return REG_NONE;
    endfunction

endpackage

// File: rtl/mtimer_sync_edge.sv
module mtimer_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // shift[STAGES-1] is the synchronised level, shift[STAGES] its previous value
    logic [STAGES:0] shift;

    always_ff @(posedge clk) begin
        if (rst) shift[0] <= 1'b0;
        else     shift[0] <= async_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) shift[i] <= 1'b0;
            else     shift[i] <= shift[i-1];
        end
    end

    assign rise = shift[STAGES-1] & ~shift[STAGES];
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;          // software write wins
        else if (tick) count <= count + W'(1);     // wraps naturally
    end
endmodule

// File: rtl/mtimer_compare.sv
module mtimer_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] count,
    output logic [W-1:0] limit,
    output logic         fire
);
    always_ff @(posedge clk) begin
        if (rst)       limit <= '1;
        else if (load) limit <= load_val;
    end

    assign fire = (count >= limit);
endmodule

// File: rtl/mtimer_ext_tick.sv
module mtimer_ext_tick
    import mtimer_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TIME_OFS    = 0,
    parameter int CMP_OFS     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timer_irq
);
    localparam int PAD_W = 32 - ADDR_W;

    reg_sel_e          sel;
    wr_ctl_t           wr;
    logic              tick;
    logic [DATA_W-1:0] time_q;
    logic [DATA_W-1:0] cmp_q;

    assign sel = decode_offset({{PAD_W{1'b0}}, bus_addr}, TIME_OFS, CMP_OFS);
    assign wr.time_wr = bus_sel && bus_we && (sel == REG_TIME);
    assign wr.cmp_wr  = bus_sel && bus_we && (sel == REG_CMP);

    mtimer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_tick),
        .rise     (tick)
    );

    mtimer_counter #(.W(DATA_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr.time_wr),
        .load_val (bus_wdata),
        .count    (time_q)
    );

    mtimer_compare #(.W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .load     (wr.cmp_wr),
        .load_val (bus_wdata),
        .count    (time_q),
        .limit    (cmp_q),
        .fire     (timer_irq)
    );

    always_comb begin
        unique case (sel)
            REG_TIME: bus_rdata = time_q;
            REG_CMP:  bus_rdata = cmp_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mtimer_checker.sv
module mtimer_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         time_wr,
    input logic         cmp_wr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] time_q,
    input logic [W-1:0] cmp_q
);
    // R2 / R8: a reference edge with no write adds one, modulo 2^W
    assert_tick_increments_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !time_wr) |=> (time_q == $past(time_q) + W'(1)));

    // R3: no edge and no write leaves the count alone
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !time_wr) |=> $stable(time_q));

    // R6: a time write always loads, even with a coincident edge
    assert_write_wins_R6: assert property (@(posedge clk) disable iff (rst)
        time_wr |=> (time_q == $past(wdata)));

    // R5: a compare write loads the compare register
    assert_cmp_load_R5: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> (cmp_q == $past(wdata)));

    // R9: without a compare write the compare value holds
    assert_cmp_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !cmp_wr |=> $stable(cmp_q));
endmodule

bind mtimer_ext_tick mtimer_checker #(.W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .time_wr (wr.time_wr),
    .cmp_wr  (wr.cmp_wr),
    .wdata   (bus_wdata),
    .time_q  (time_q),
    .cmp_q   (cmp_q)
);

// File: tb/mtimer_ext_tick_bench.sv
module mtimer_ext_tick_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        timer_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    mtimer_ext_tick u_mtimer_ext_tick (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq)
    );

    // ---------------- behavioural reference model ----------------
    bit          samples[$];       // last four reference samples, oldest first
    logic [31:0] m_time;
    logic [31:0] m_cmp;

    always @(posedge clk) begin
        if (rst) begin
            samples = '{0, 0, 0, 0};
            m_time  = 32'h0;
            m_cmp   = 32'hFFFF_FFFF;
        end else begin
            bit bump;
            samples.push_back(ref_tick);
            void'(samples.pop_front());
            // a sample that rose two edges ago lands now
            bump = samples[1] && !samples[0];
            if (bus_sel && bus_we && bus_addr == 4'h0)      m_time = bus_wdata;
            else if (bump)                                  m_time = m_time + 1;
            if (bus_sel && bus_we && bus_addr == 4'h4)      m_cmp  = bus_wdata;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [31:0] exp_rd;
            exp_rd = (bus_addr == 4'h0) ? m_time :
                     (bus_addr == 4'h4) ? m_cmp  : 32'h0;
            check(bus_rdata === exp_rd, "R4 model read", bus_rdata, exp_rd);
            check(timer_irq === (m_time >= m_cmp), "R7 model irq",
                  {31'h0, timer_irq}, {31'h0, m_time >= m_cmp});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 ref_tick = 1'b1;
            cyc(3);
            ref_tick = 1'b0;
            cyc(3);
        end
        cyc(4);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] rd;
        logic [31:0] held;
        cyc(3);
        rst = 1'b0;

        // R1 reset state
        bus_read(4'h0, rd); check(rd == 32'h0, "R1 time after reset", rd, 32'h0);
        bus_read(4'h4, rd); check(rd == 32'hFFFF_FFFF, "R1 compare after reset", rd, 32'hFFFF_FFFF);
        check(timer_irq == 1'b0, "R1 irq after reset", {31'h0, timer_irq}, 32'h0);

        // R2 five reference edges
        pulses(5);
        bus_read(4'h0, rd); check(rd == 32'd5, "R2 five edges", rd, 32'd5);

        // R3 held high: one rise, then nothing more
        @(posedge clk); #1 ref_tick = 1'b1;
        cyc(5);
        bus_read(4'h0, held); check(held == 32'd6, "R3 single rise", held, 32'd6);
        cyc(20);
        bus_read(4'h0, rd); check(rd == held, "R3 held high", rd, held);
        ref_tick = 1'b0; cyc(10);
        bus_read(4'h0, rd); check(rd == held, "R3 falling edge", rd, held);

        // R5 loads, R9 cross independence
        bus_write(4'h0, 32'h100);
        bus_read(4'h0, rd); check(rd == 32'h100, "R5 time load", rd, 32'h100);
        bus_write(4'h4, 32'h105);
        bus_read(4'h4, rd); check(rd == 32'h105, "R5 compare load", rd, 32'h105);
        bus_read(4'h0, rd); check(rd == 32'h100, "R9 time untouched by compare write", rd, 32'h100);
        check(timer_irq == 1'b0, "R7 below compare", {31'h0, timer_irq}, 32'h0);
        pulses(4);
        check(timer_irq == 1'b0, "R7 one below compare", {31'h0, timer_irq}, 32'h0);
        pulses(1);
        check(timer_irq == 1'b1, "R7 equal fires", {31'h0, timer_irq}, 32'h1);
        pulses(1);
        check(timer_irq == 1'b1, "R7 above fires", {31'h0, timer_irq}, 32'h1);
        bus_write(4'h4, 32'h200);
        check(timer_irq == 1'b0, "R7 cleared by larger compare", {31'h0, timer_irq}, 32'h0);

        // R7 unsigned compare across the sign bit
        bus_write(4'h4, 32'h8000_0000);
        bus_write(4'h0, 32'h7FFF_FFFF);
        check(timer_irq == 1'b0, "R7 unsigned below", {31'h0, timer_irq}, 32'h0);
        pulses(1);
        check(timer_irq == 1'b1, "R7 unsigned reach", {31'h0, timer_irq}, 32'h1);

        // R6 write coincides with an increment
        @(posedge clk); #1 ref_tick = 1'b1;       // sampled at next edge k
        @(posedge clk);                             // edge k
        @(posedge clk); #1;                         // edge k+1
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0000_0ABC;
        @(posedge clk); #1;                         // edge k+2: write and increment
        bus_sel = 1'b0; bus_we = 1'b0;
        ref_tick = 1'b0;
        cyc(4);
        bus_read(4'h0, rd); check(rd == 32'h0000_0ABC, "R6 write wins", rd, 32'h0000_0ABC);

        // R8 wrap
        bus_write(4'h0, 32'hFFFF_FFFF);
        pulses(1);
        bus_read(4'h0, rd); check(rd == 32'h0, "R8 wrap to zero", rd, 32'h0);

        // R9 unused offset
        bus_write(4'h4, 32'h0000_1234);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h0, rd); check(rd == 32'h0, "R9 time after stray write", rd, 32'h0);
        bus_read(4'h4, rd); check(rd == 32'h0000_1234, "R9 compare after stray write", rd, 32'h0000_1234);
        bus_read(4'h8, rd); check(rd == 32'h0, "R4 unused offset reads zero", rd, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule